// File: doc/BRIEF.md
# DRAM Command Timing Tracker

This block sits beside the command scheduler of a memory controller for a packet-based DRAM. The DRAM has one row command channel and one column command channel. The scheduler presents a candidate command on each channel: a bank number and an operation. The block answers with a ready signal. Ready is high only once every minimum spacing to earlier commands has elapsed. Some of these spacings are counted per bank, some across the whole device, and some from the last column command of a burst to the precharge that closes the bank.

A command takes effect when the scheduler pulses the issue strobe for its channel. A strobe that arrives while ready is low is still applied to all timers and bank state. The block then reports it one cycle later as a registered violation pulse, together with the bank and operation involved. Column commands to a bank that is not open are flagged as a distinct cause. Each bank also counts its open time and raises a sticky flag once a programmable limit is reached. That limit is the core's microsecond open-time ceiling converted to clock cycles.

Top module: `dram_cmd_timer`

## Requirements
- R1: An activate (row op 0) is ready only if its bank is closed, at least T_RC cycles have passed since the last activate to that bank, and at least T_RP cycles have passed since the last precharge to that bank.
- R2: Activates to any banks are at least T_RR cycles apart, and precharges (row op 1) to any banks are at least T_PP cycles apart.
- R3: A precharge is ready only once T_RAS cycles have passed since the last activate to that bank.
- R4: A precharge is held off for T_RDP cycles after the last read to that bank, and for T_RTP cycles after the last retire to that bank.
- R5: Read (col op 0) and write (col op 1) are ready only when the bank is open (activated and not precharged since) and T_RCD cycles have passed since its activate.
- R6: Any two column commands are at least T_CC cycles apart, whatever their banks.
- R7: Retire (col op 2) and mask (col op 3) wait T_RTR cycles after the last write to any bank, and also need the bank open.
- R8: A bank that stays open for OPEN_LIMIT cycles raises its overrun flag on that edge, and the flag stays set until reset.
- R9: A row issue strobe while the row command is not allowed gives a one-cycle row_viol pulse on the next cycle, with the bank and op captured.
- R10: A column issue strobe while not allowed gives a one-cycle col_viol pulse on the next cycle, with the bank and op captured; col_viol_closed is 1 when the bank was closed.
- R11: A command issued in violation still restarts every timer it affects and changes the bank state.
- R12: After reset all banks are closed, all spacings count as elapsed, and no overrun or violation is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_valid | input | 1 | Row candidate present |
| row_op | input | 1 | Row op: 0 activate, 1 precharge |
| row_bank | input | BANK_W | Row candidate bank |
| row_issue | input | 1 | Row command issued this cycle |
| row_ready | output | 1 | Row candidate allowed now |
| col_valid | input | 1 | Column candidate present |
| col_op | input | 2 | Column op: 0 read, 1 write, 2 retire, 3 mask |
| col_bank | input | BANK_W | Column candidate bank |
| col_issue | input | 1 | Column command issued this cycle |
| col_ready | output | 1 | Column candidate allowed now |
| open_overrun | output | NUM_BANKS | Sticky open-time overrun per bank |
| row_viol | output | 1 | Row violation pulse |
| row_viol_bank | output | BANK_W | Bank of the row violation |
| row_viol_op | output | 1 | Op of the row violation |
| col_viol | output | 1 | Column violation pulse |
| col_viol_bank | output | BANK_W | Bank of the column violation |
| col_viol_op | output | 2 | Op of the column violation |
| col_viol_closed | output | 1 | Column violation was to a closed bank |

## Verification
The bench builds the block with two banks, a 6-bit interval counter, OPEN_LIMIT of 40 and T_RC raised to 36, keeping the other spacings at their defaults. The raised row cycle makes the same-bank activate spacing the binding limit rather than the sum of the open and precharge minimums. The short open limit makes the overrun edge reachable within a short run. Two banks are enough for the device-wide rules to be seen separately from the per-bank ones.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [0:0] {ROW_ACT = 1'b0, ROW_PRE = 1'b1} row_op_e;
  typedef enum logic [1:0] {
    COL_RD  = 2'd0,
    COL_WR  = 2'd1,
    COL_RET = 2'd2,
    COL_MSK = 2'd3
  } col_op_e;
endpackage

// File: rtl/dct_sat_cnt.sv
module dct_sat_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= TOP;
    else if (clr)         cnt_q <= '0;
    else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R11
  cnt_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/dct_bank.sv
module dct_bank #(
  parameter int CNT_W      = 6,
  parameter int OPEN_LIMIT = 25600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             rd_i,
  input  logic             ret_i,
  output logic             open_o,
  output logic [CNT_W-1:0] since_act_o,
  output logic [CNT_W-1:0] since_pre_o,
  output logic [CNT_W-1:0] since_rd_o,
  output logic [CNT_W-1:0] since_ret_o,
  output logic             overrun_o
);
  localparam int OPEN_W = $clog2(OPEN_LIMIT + 1);
  localparam logic [OPEN_W-1:0] LIM      = OPEN_W'(OPEN_LIMIT);
  localparam logic [OPEN_W-1:0] LIM_LAST = OPEN_W'(OPEN_LIMIT - 1);

  logic              open_q;
  logic [OPEN_W-1:0] open_cnt_q;
  logic              overrun_q;

  always_ff @(posedge clk) begin
    if (rst)        open_q <= 1'b0;
    else if (act_i) open_q <= 1'b1;
    else if (pre_i) open_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || act_i)                    open_cnt_q <= '0;
    else if (open_q && open_cnt_q != LIM) open_cnt_q <= open_cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) overrun_q <= 1'b0;
    else if (open_q && !act_i && open_cnt_q == LIM_LAST) overrun_q <= 1'b1;
  end

  dct_sat_cnt #(.W(CNT_W)) u_act (.clk(clk), .rst(rst), .clr(act_i), .cnt_o(since_act_o));
  dct_sat_cnt #(.W(CNT_W)) u_pre (.clk(clk), .rst(rst), .clr(pre_i), .cnt_o(since_pre_o));
  dct_sat_cnt #(.W(CNT_W)) u_rd  (.clk(clk), .rst(rst), .clr(rd_i),  .cnt_o(since_rd_o));
  dct_sat_cnt #(.W(CNT_W)) u_ret (.clk(clk), .rst(rst), .clr(ret_i), .cnt_o(since_ret_o));

  assign open_o    = open_q;
  assign overrun_o = overrun_q;

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun_q |=> overrun_q);

  // R8
  overrun_needs_open_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_q) |-> $past(open_q));
endmodule

// File: rtl/dram_cmd_timer.sv
module dram_cmd_timer
  import dct_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int CNT_W      = 6,
  parameter int T_RC       = 28,
  parameter int T_RAS      = 20,
  parameter int T_RP       = 8,
  parameter int T_PP       = 8,
  parameter int T_RR       = 8,
  parameter int T_RCD      = 9,
  parameter int T_CC       = 4,
  parameter int T_RDP      = 4,
  parameter int T_RTP      = 4,
  parameter int T_RTR      = 8,
  parameter int OPEN_LIMIT = 25600,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 row_valid,
  input  logic                 row_op,
  input  logic [BANK_W-1:0]    row_bank,
  input  logic                 row_issue,
  output logic                 row_ready,
  input  logic                 col_valid,
  input  logic [1:0]           col_op,
  input  logic [BANK_W-1:0]    col_bank,
  input  logic                 col_issue,
  output logic                 col_ready,
  output logic [NUM_BANKS-1:0] open_overrun,
  output logic                 row_viol,
  output logic [BANK_W-1:0]    row_viol_bank,
  output logic                 row_viol_op,
  output logic                 col_viol,
  output logic [BANK_W-1:0]    col_viol_bank,
  output logic [1:0]           col_viol_op,
  output logic                 col_viol_closed
);
  // counters read "elapsed edges minus one", so a spacing of N needs N-1
  localparam logic [CNT_W-1:0] L_RC  = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] L_RAS = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] L_PP  = CNT_W'(T_PP - 1);
  localparam logic [CNT_W-1:0] L_RR  = CNT_W'(T_RR - 1);
  localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] L_CC  = CNT_W'(T_CC - 1);
  localparam logic [CNT_W-1:0] L_RDP = CNT_W'(T_RDP - 1);
  localparam logic [CNT_W-1:0] L_RTP = CNT_W'(T_RTP - 1);
  localparam logic [CNT_W-1:0] L_RTR = CNT_W'(T_RTR - 1);

  logic                 row_is_act, row_is_pre;
  logic                 col_is_rd, col_is_wr, col_is_ret;
  logic [NUM_BANKS-1:0] act_v, pre_v, rd_v, ret_v, open_v;
  logic [CNT_W-1:0]     s_act [NUM_BANKS];
  logic [CNT_W-1:0]     s_pre [NUM_BANKS];
  logic [CNT_W-1:0]     s_rd  [NUM_BANKS];
  logic [CNT_W-1:0]     s_ret [NUM_BANKS];
  logic [CNT_W-1:0]     g_act, g_pre, g_col, g_wr;
  logic                 row_allowed, col_allowed;

  assign row_is_act = (row_op_e'(row_op) == ROW_ACT);
  assign row_is_pre = (row_op_e'(row_op) == ROW_PRE);
  assign col_is_rd  = (col_op_e'(col_op) == COL_RD);
  assign col_is_wr  = (col_op_e'(col_op) == COL_WR);
  assign col_is_ret = (col_op_e'(col_op) == COL_RET);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign act_v[b] = row_issue && row_is_act && (row_bank == BANK_W'(b));
    assign pre_v[b] = row_issue && row_is_pre && (row_bank == BANK_W'(b));
    assign rd_v[b]  = col_issue && col_is_rd  && (col_bank == BANK_W'(b));
    assign ret_v[b] = col_issue && col_is_ret && (col_bank == BANK_W'(b));

    dct_bank #(.CNT_W(CNT_W), .OPEN_LIMIT(OPEN_LIMIT)) u_bank (
      .clk(clk), .rst(rst),
      .act_i(act_v[b]), .pre_i(pre_v[b]), .rd_i(rd_v[b]), .ret_i(ret_v[b]),
      .open_o(open_v[b]),
      .since_act_o(s_act[b]), .since_pre_o(s_pre[b]),
      .since_rd_o(s_rd[b]), .since_ret_o(s_ret[b]),
      .overrun_o(open_overrun[b])
    );
  end

  dct_sat_cnt #(.W(CNT_W)) u_g_act (.clk(clk), .rst(rst),
    .clr(row_issue && row_is_act), .cnt_o(g_act));
  dct_sat_cnt #(.W(CNT_W)) u_g_pre (.clk(clk), .rst(rst),
    .clr(row_issue && row_is_pre), .cnt_o(g_pre));
  dct_sat_cnt #(.W(CNT_W)) u_g_col (.clk(clk), .rst(rst),
    .clr(col_issue), .cnt_o(g_col));
  dct_sat_cnt #(.W(CNT_W)) u_g_wr  (.clk(clk), .rst(rst),
    .clr(col_issue && col_is_wr), .cnt_o(g_wr));

  always_comb begin
    if (row_is_act)
      row_allowed = !open_v[row_bank] && (s_act[row_bank] >= L_RC) &&
                    (s_pre[row_bank] >= L_RP) && (g_act >= L_RR);
    else
      row_allowed = (s_act[row_bank] >= L_RAS) && (g_pre >= L_PP) &&
                    (s_rd[row_bank] >= L_RDP) && (s_ret[row_bank] >= L_RTP);
  end

  always_comb begin
    col_allowed = open_v[col_bank] && (g_col >= L_CC);
    if (col_is_rd || col_is_wr) col_allowed = col_allowed && (s_act[col_bank] >= L_RCD);
    else                        col_allowed = col_allowed && (g_wr >= L_RTR);
  end

  assign row_ready = row_valid && row_allowed;
  assign col_ready = col_valid && col_allowed;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_viol        <= 1'b0;
      row_viol_bank   <= '0;
      row_viol_op     <= 1'b0;
      col_viol        <= 1'b0;
      col_viol_bank   <= '0;
      col_viol_op     <= '0;
      col_viol_closed <= 1'b0;
    end else begin
      row_viol <= row_issue && !row_allowed;
      col_viol <= col_issue && !col_allowed;
      if (row_issue) begin
        row_viol_bank <= row_bank;
        row_viol_op   <= row_op;
      end
      if (col_issue) begin
        col_viol_bank   <= col_bank;
        col_viol_op     <= col_op;
        col_viol_closed <= !open_v[col_bank];
      end
    end
  end

  // R2
  act_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (T_RR > 1) && row_issue && row_is_act |=> !(row_ready && row_is_act));

  // R6
  col_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (T_CC > 1) && col_issue |=> !col_ready);
endmodule

// File: tb/dram_cmd_timer_tb.sv
module dram_cmd_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;
  localparam int BW = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic row_valid = 0, row_op = 0, row_issue = 0;
  logic [BW-1:0] row_bank = '0;
  logic col_valid = 0, col_issue = 0;
  logic [1:0] col_op = '0;
  logic [BW-1:0] col_bank = '0;
  logic row_ready, col_ready, row_viol, row_viol_op, col_viol, col_viol_closed;
  logic [BW-1:0] row_viol_bank, col_viol_bank;
  logic [1:0] col_viol_op;
  logic [NB-1:0] open_overrun;

  int checks = 0;
  int errors = 0;
  int now = 0;
  bit done = 0;

  typedef struct { bit chan; int bank; int op; bit closed; } ev_t;
  ev_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cmd_timer #(
    .NUM_BANKS(NB), .CNT_W(6), .T_RC(36), .OPEN_LIMIT(40)
  ) u_dut (
    .clk(clk), .rst(rst),
    .row_valid(row_valid), .row_op(row_op), .row_bank(row_bank),
    .row_issue(row_issue), .row_ready(row_ready),
    .col_valid(col_valid), .col_op(col_op), .col_bank(col_bank),
    .col_issue(col_issue), .col_ready(col_ready),
    .open_overrun(open_overrun),
    .row_viol(row_viol), .row_viol_bank(row_viol_bank), .row_viol_op(row_viol_op),
    .col_viol(col_viol), .col_viol_bank(col_viol_bank), .col_viol_op(col_viol_op),
    .col_viol_closed(col_viol_closed)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at edge %0d: got %0d exp %0d", req, now, act, exp);
    end
  endtask

  // monitor: pops expected violation records as pulses appear
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (row_viol || col_viol) begin
        if (exp_q.size() == 0) begin
          chk(row_viol ? "R9 spurious row_viol" : "R10 spurious col_viol", 1, 0);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(e.chan ? "R10 channel" : "R9 channel", int'(col_viol), int'(e.chan));
          if (e.chan) begin
            chk("R10 bank", int'(col_viol_bank), e.bank);
            chk("R10 op", int'(col_viol_op), e.op);
            chk("R10 closed", int'(col_viol_closed), int'(e.closed));
          end else begin
            chk("R9 bank", int'(row_viol_bank), e.bank);
            chk("R9 op", int'(row_viol_op), e.op);
          end
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
    now++;
  endtask

  task automatic to_edge(int k);
    while (now < k) step();
  endtask

  task automatic probe_row(int op, int bank, int exp, string req);
    row_valid = 1; row_op = op[0]; row_bank = bank[BW-1:0];
    #1;
    chk(req, int'(row_ready), exp);
  endtask

  task automatic probe_col(int op, int bank, int exp, string req);
    col_valid = 1; col_op = op[1:0]; col_bank = bank[BW-1:0];
    #1;
    chk(req, int'(col_ready), exp);
  endtask

  task automatic row_go(int op, int bank, bit viol);
    ev_t e;
    row_valid = 1; row_op = op[0]; row_bank = bank[BW-1:0]; row_issue = 1;
    if (viol) begin
      e.chan = 0; e.bank = bank; e.op = op; e.closed = 0;
      exp_q.push_back(e);
    end
    step();
    row_issue = 0;
  endtask

  task automatic col_go(int op, int bank, bit viol, bit closed);
    ev_t e;
    col_valid = 1; col_op = op[1:0]; col_bank = bank[BW-1:0]; col_issue = 1;
    if (viol) begin
      e.chan = 1; e.bank = bank; e.op = op; e.closed = closed;
      exp_q.push_back(e);
    end
    step();
    col_issue = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 3000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at edge %0d: got 1 exp 0", now);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    now = 0;
    // R12 reset state
    probe_row(0, 0, 1, "R12 act ready after reset");
    probe_row(1, 1, 1, "R12 pre ready after reset");
    probe_col(0, 0, 0, "R12 banks closed after reset");
    chk("R12 overrun clear", int'(open_overrun), 0);
    chk("R12 no row_viol", int'(row_viol), 0);

    row_go(0, 0, 0);                         // ACT b0 @E0
    to_edge(7);  probe_row(0, 1, 0, "R2 act-act any bank too soon");
    to_edge(8);  probe_row(0, 1, 1, "R2 act-act any bank elapsed");
    row_go(0, 1, 0);                         // ACT b1 @E8
    probe_col(0, 0, 1, "R5 read after rcd");
    probe_col(0, 1, 0, "R5 read before rcd");
    col_go(0, 0, 0, 0);                      // RD b0 @E9
    probe_col(1, 0, 0, "R6 col spacing too soon");
    to_edge(12); probe_col(1, 0, 0, "R6 col spacing one short");
    to_edge(13); probe_col(1, 0, 1, "R6 col spacing elapsed");
    col_go(1, 0, 0, 0);                      // WR b0 @E13
    to_edge(20); probe_col(2, 0, 0, "R7 retire before rtr");
    to_edge(21); probe_col(2, 0, 1, "R7 retire after rtr");
    col_go(2, 0, 0, 0);                      // RET b0 @E21
    to_edge(24); probe_row(1, 0, 0, "R4 pre after retire too soon");
    to_edge(25); probe_row(1, 0, 1, "R4 pre after retire elapsed");
    row_go(1, 0, 0);                         // PRE b0 @E25
    probe_row(1, 1, 0, "R3 pre before ras");
    to_edge(32); probe_row(1, 1, 0, "R2 pre-pre too soon");
    to_edge(33); probe_row(1, 1, 1, "R2 pre-pre elapsed");
    row_go(1, 1, 0);                         // PRE b1 @E33
    to_edge(35); probe_row(0, 0, 0, "R1 act before rc");
    to_edge(36); probe_row(0, 0, 1, "R1 act after rc");
    row_go(0, 0, 0);                         // ACT b0 @E36
    to_edge(76); chk("R8 overrun not yet", int'(open_overrun[0]), 0);
    to_edge(77); chk("R8 overrun set", int'(open_overrun[0]), 1);
    chk("R8 other bank clear", int'(open_overrun[1]), 0);
    to_edge(79); probe_row(0, 0, 0, "R1 act to open bank");
    to_edge(80); row_go(0, 1, 0);            // ACT b1 @E80
    to_edge(90); chk("R8 overrun sticky", int'(open_overrun[0]), 1);
    to_edge(120); row_go(1, 1, 0);           // PRE b1 @E120
    to_edge(127); probe_row(0, 1, 0, "R1 act before rp");
    to_edge(128); probe_row(0, 1, 1, "R1 act after rp");
    row_go(0, 1, 0);                         // ACT b1 @E128
    row_go(1, 1, 1);                         // forced PRE b1 @E129 -> R9
    probe_col(0, 1, 0, "R11 forced pre closed bank");
    col_go(0, 1, 1, 1);                      // forced RD b1 closed @E130 -> R10
    col_go(1, 0, 1, 0);                      // forced WR b0 tCC @E131 -> R10
    to_edge(134); probe_col(0, 0, 0, "R11 violating col restarted spacing");
    to_edge(135); probe_col(1, 0, 1, "R11 col ready after restart");
    col_go(1, 0, 0, 0);                      // WR b0 @E135
    to_edge(139); probe_col(3, 0, 0, "R7 mask before rtr");
    to_edge(143); probe_col(3, 0, 1, "R7 mask after rtr");
    step(); step();
    chk("R9 R10 all expected violations seen", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule